// File: doc/BRIEF.md
# Keyed serial-channel unlock sequencer

This block watches the stream of read and write cycles on a byte-wide memory bus. It opens a hidden one-bit-wide side channel to a 64-bit timekeeping register image. No address is reserved for the channel. Software unlocks it by issuing 64 selected write cycles in a row. Each of these writes carries one bit of a fixed key on data line 0. Until the key is complete, every cycle is left to the ordinary memory. Once the key has matched, the block takes the next 64 selected cycles away from memory by raising an inhibit flag. It then moves one bit of the clock image per cycle: writes shift a bit in and reads shift a bit out.

A read during recognition restarts the hunt from the first key bit. A wrong bit freezes progress silently until the next read. Bits written during a transfer collect in a shadow register. They are handed to the clock as one parallel load after the final transfer cycle. A per-byte mask marks the register groups that received a full set of eight written bits. A read transfer returns the clock image as it stood when the key completed. An external abort pin can cancel a transfer when the captured image allows it.

Top module: `pattern_unlock_seq`

## Requirements
- R1: A selected read cycle outside a transfer returns recognition to key bit 0 and clears any stall. A cycle with both strobes high counts as a read.
- R2: A selected write cycle outside a transfer compares `dq0_in` with the key bit at the pointer. On a match the pointer advances. On a mismatch recognition stalls, and all later writes are ignored until a read.
- R3: Key bit i is bit (i mod 8) of byte i/8 of the sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, so each byte goes least significant bit first. `img_capture` is high during exactly the write that matches the last key bit.
- R4: `mem_inhibit` is low during recognition, including the final key write. It is high from the next cycle on, for the 64 selected transfer cycles.
- R5: The selected write at transfer position k (0 to 63) places `dq0_in` in bit k of `load_data`.
- R6: The selected read at transfer position k drives bit k of `clk_image_in` onto `dq0_out`, taken from the cycle in which `img_capture` was high. Later changes of `clk_image_in` do not affect it.
- R7: In the cycle after the 64th transfer cycle, `load_stb` is high for one cycle and `mem_inhibit` falls. Bit g of `load_mask` is 1 exactly when all eight positions 8g..8g+7 were writes. The sequencer is then back at key bit 0 with no read needed.
- R8: Cycles with `cyc_sel` low have no effect on recognition or on the transfer position.
- R9: Bit 36 of the captured image (bit 4 of register 4) is the abort enable. When it is 0, a low `abort_n` during a transfer ends the transfer in the next cycle without `load_stb`. When it is 1, `abort_n` is ignored.
- R10: After reset the sequencer is in recognition at key bit 0. `mem_inhibit`, `dq0_out`, `load_stb` and `load_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_rd | input | 1 | A read cycle occurs in this clock |
| cyc_wr | input | 1 | A write cycle occurs in this clock |
| cyc_sel | input | 1 | The cycle targets this block's memory range |
| dq0_in | input | 1 | Data line 0 during a write |
| abort_n | input | 1 | Active-low transfer abort pin |
| clk_image_in | input | 64 | Present clock register image, register 0 in bits 7:0 |
| mem_inhibit | output | 1 | Memory access must be suppressed for this cycle |
| dq0_out | output | 1 | Serial clock bit for a transfer read |
| img_capture | output | 1 | The clock image is being captured (key completed) |
| load_stb | output | 1 | One-cycle commit of `load_data` to the clock |
| load_data | output | 64 | Assembled write image |
| load_mask | output | 8 | Groups whose eight bits were all written |

## Verification
The bench uses the default parameters: a 64-bit key, a 64-bit transfer, 8-bit groups and the abort enable at bit 36. These sizes let it send the real key byte sequence in full. They also let it break the key at its first, middle and last bits, and place a read inside one byte group to clear exactly one mask bit. Two clock images are used, one with the abort enable clear and one with it set, so both abort outcomes are exercised. Swapping the image during a transfer shows that read data comes from the snapshot.

// File: rtl/upk_pkg.sv
package upk_pkg;

  // Key bytes C5 3A A3 5C twice; byte 0 in bits 7:0, streamed LSB first.
  localparam logic [63:0] UPK_KEY = 64'h5CA33AC5_5CA33AC5;

  typedef enum logic {PH_HUNT = 1'b0, PH_XFER = 1'b1} phase_e;

  // Group a transfer position falls in.
  function automatic int unsigned group_of(input int unsigned pos,
                                           input int unsigned width);
    return pos / width;
  endfunction

endpackage

// File: rtl/key_matcher.sv
module key_matcher #(
  parameter int          KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = upk_pkg::UPK_KEY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en,
  input  logic rd_q,
  input  logic wr_q,
  input  logic bit_in,
  output logic hit
);
  localparam int PTR_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_W - 1);

  logic [PTR_W-1:0] ptr;
  logic             stalled;
  logic             bit_ok;
  logic             wr_only;

  assign bit_ok  = (bit_in == KEY[ptr]);
  assign wr_only = wr_q && !rd_q;
  assign hit     = hunt_en && wr_only && !stalled && bit_ok && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      stalled <= 1'b0;
    end else if (hunt_en) begin
      if (rd_q) begin
        ptr     <= '0;
        stalled <= 1'b0;
      end else if (wr_q && !stalled) begin
        if (!bit_ok)          stalled <= 1'b1;
        else if (ptr == LAST) ptr     <= '0;
        else                  ptr     <= ptr + 1'b1;
      end
    end
  end

  AST_READ_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_en && rd_q |=> (ptr == '0) && !stalled) else $error("read did not rewind"); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_en && stalled && wr_only |=> stalled && $stable(ptr)) else $error("stall broken"); // R2

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int XFER_W    = 64,
  parameter int GRP_W     = 8,
  parameter int ABORT_BIT = 36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [XFER_W-1:0]         image_in,
  input  logic                      rd_q,
  input  logic                      wr_q,
  input  logic                      bit_in,
  input  logic                      abort_req,
  output logic                      busy,
  output logic                      bit_out,
  output logic                      load_stb,
  output logic [XFER_W-1:0]         load_data,
  output logic [XFER_W/GRP_W-1:0]   load_mask
);
  localparam int NGRP   = XFER_W / GRP_W;
  localparam int CNT_W  = (XFER_W > 1) ? $clog2(XFER_W) : 1;
  localparam int GIDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_W - 1);

  upk_pkg::phase_e  phase;
  logic [CNT_W-1:0] cnt;
  logic [XFER_W-1:0] snap;
  logic [XFER_W-1:0] shadow;
  logic [NGRP-1:0]  grp_ok;
  logic [NGRP-1:0]  grp_next;
  logic             step;
  logic             is_wr;
  logic             abort_hit;
  logic             last_step;
  logic [GIDX_W-1:0] gidx;

  assign busy      = (phase == upk_pkg::PH_XFER);
  assign step      = busy && (rd_q || wr_q);
  assign is_wr     = wr_q && !rd_q;
  assign abort_hit = busy && abort_req && !snap[ABORT_BIT];
  assign last_step = step && !abort_hit && (cnt == LAST);
  assign gidx      = GIDX_W'(upk_pkg::group_of(32'(cnt), GRP_W));
  assign bit_out   = busy && snap[cnt];
  assign load_data = shadow;

  always_comb begin
    grp_next = grp_ok;
    if (!is_wr) grp_next[gidx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= upk_pkg::PH_HUNT;
      cnt       <= '0;
      snap      <= '0;
      shadow    <= '0;
      grp_ok    <= '1;
      load_stb  <= 1'b0;
      load_mask <= '0;
    end else begin
      load_stb <= 1'b0;
      if (start) begin
        phase  <= upk_pkg::PH_XFER;
        cnt    <= '0;
        snap   <= image_in;
        grp_ok <= '1;
      end else if (abort_hit) begin
        phase <= upk_pkg::PH_HUNT;
        cnt   <= '0;
      end else if (step) begin
        if (is_wr) shadow[cnt] <= bit_in;
        grp_ok <= grp_next;
        if (last_step) begin
          phase     <= upk_pkg::PH_HUNT;
          cnt       <= '0;
          load_stb  <= 1'b1;
          load_mask <= grp_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_ABORT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !busy && !load_stb) else $error("abort ignored"); // R9
  AST_LOAD_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(busy) && !busy) else $error("stray load"); // R7
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb) else $error("load longer than one cycle"); // R7

endmodule

// File: rtl/pattern_unlock_seq.sv
module pattern_unlock_seq #(
  parameter int          KEY_W     = 64,
  parameter logic [KEY_W-1:0] KEY  = upk_pkg::UPK_KEY,
  parameter int          XFER_W    = 64,
  parameter int          GRP_W     = 8,
  parameter int          ABORT_BIT = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_rd,
  input  logic                    cyc_wr,
  input  logic                    cyc_sel,
  input  logic                    dq0_in,
  input  logic                    abort_n,
  input  logic [XFER_W-1:0]       clk_image_in,
  output logic                    mem_inhibit,
  output logic                    dq0_out,
  output logic                    img_capture,
  output logic                    load_stb,
  output logic [XFER_W-1:0]       load_data,
  output logic [XFER_W/GRP_W-1:0] load_mask
);
  logic rd_q;
  logic wr_q;
  logic key_hit;
  logic busy;

  assign rd_q        = cyc_sel && cyc_rd;
  assign wr_q        = cyc_sel && cyc_wr && !cyc_rd;
  assign mem_inhibit = busy;
  assign img_capture = key_hit;

  key_matcher #(.KEY_W(KEY_W), .KEY(KEY)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .hunt_en (!busy),
    .rd_q    (rd_q),
    .wr_q    (wr_q),
    .bit_in  (dq0_in),
    .hit     (key_hit)
  );

  xfer_engine #(.XFER_W(XFER_W), .GRP_W(GRP_W), .ABORT_BIT(ABORT_BIT)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (key_hit),
    .image_in  (clk_image_in),
    .rd_q      (rd_q),
    .wr_q      (wr_q),
    .bit_in    (dq0_in),
    .abort_req (!abort_n),
    .busy      (busy),
    .bit_out   (dq0_out),
    .load_stb  (load_stb),
    .load_data (load_data),
    .load_mask (load_mask)
  );

  AST_UNLOCK_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> mem_inhibit) else $error("no inhibit after key"); // R4
  AST_INHIBIT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_inhibit) |-> $past(key_hit)) else $error("inhibit without key"); // R4
  AST_UNSEL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit && !cyc_sel && abort_n |=> mem_inhibit && !load_stb) else $error("unselected cycle moved transfer"); // R8

endmodule

// File: tb/pattern_unlock_seq_bench.sv
module pattern_unlock_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_rd = 1'b0, cyc_wr = 1'b0, cyc_sel = 1'b0, dq0_in = 1'b0, abort_n = 1'b1;
  logic [63:0] clk_image_in;
  logic        mem_inhibit, dq0_out, img_capture, load_stb;
  logic [63:0] load_data;
  logic [7:0]  load_mask;

  localparam logic [63:0] IMG_A = 64'h0123_4567_89AB_CDEF; // bit 36 = 0
  localparam logic [63:0] IMG_B = 64'hFEDC_BA98_7654_3210; // bit 36 = 1
  localparam logic [63:0] WPAT  = 64'hDEAD_BEEF_CAFE_F00D;
  localparam logic [63:0] MPAT  = 64'h1357_9BDF_2468_ACE0;
  localparam logic [7:0]  KB [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
  // {expect_unlock, kind, prefix}; kind 0 clean, 1 read at prefix, 2 wrong bit at prefix, 3 interleaved unselected
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 2'd0, 7'd0},  {1'b1, 2'd1, 7'd5},  {1'b1, 2'd1, 7'd63}, {0'b0 | 1'b0, 2'd2, 7'd0},
    {1'b0, 2'd2, 7'd17}, {1'b0, 2'd2, 7'd63}, {1'b1, 2'd3, 7'd0},  {1'b1, 2'd1, 7'd40}};

  int checks = 0, errors = 0;
  logic s_inh, s_dq, s_cap, s_ld;
  logic [63:0] s_ldata;
  logic [7:0]  s_lmask;

  pattern_unlock_seq u_pattern_unlock_seq (
    .clk(clk), .rst_n(rst_n), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr), .cyc_sel(cyc_sel),
    .dq0_in(dq0_in), .abort_n(abort_n), .clk_image_in(clk_image_in),
    .mem_inhibit(mem_inhibit), .dq0_out(dq0_out), .img_capture(img_capture),
    .load_stb(load_stb), .load_data(load_data), .load_mask(load_mask));

  always #5 clk = ~clk;

  function automatic logic kbit(input int i);
    return KB[(i / 8) % 4][i % 8];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic sel, input logic d,
                      input logic ab = 1'b1);
    @(negedge clk);
    cyc_rd = rd; cyc_wr = wr; cyc_sel = sel; dq0_in = d; abort_n = ab;
    #1;
    s_inh = mem_inhibit; s_dq = dq0_out; s_cap = img_capture;
    s_ld = load_stb; s_ldata = load_data; s_lmask = load_mask;
    @(posedge clk);
    #1;
    cyc_rd = 1'b0; cyc_wr = 1'b0; cyc_sel = 1'b0; abort_n = 1'b1;
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) step(1'b0, 1'b1, 1'b1, kbit(i));
  endtask

  // Drain a transfer with reads from position 'from', checking snapshot data.
  task automatic drain_reads(input int from, input logic [63:0] img);
    for (int i = from; i < 64; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0);
      check(s_dq == img[i], "R6 read bit", 64'(s_dq), 64'(img[i]));
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clk_image_in = IMG_A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(!s_inh && !s_dq && !s_ld && s_lmask == 8'h00, "R10 reset outputs",
          {s_lmask, 53'd0, s_inh, s_dq, s_ld}, 64'd0);

    // Table of recognition scenarios
    for (int n = 0; n < 8; n++) begin
      logic       exp_u;
      logic [1:0] kind;
      int         pre;
      exp_u = VEC[n][9]; kind = VEC[n][8:7]; pre = int'(VEC[n][6:0]);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      case (kind)
        2'd0: send_key(0, 64);
        2'd1: begin send_key(0, pre); step(1'b1, 1'b0, 1'b1, 1'b0); send_key(0, 64); end // R1
        2'd2: begin send_key(0, pre); step(1'b0, 1'b1, 1'b1, ~kbit(pre)); send_key(pre + 1, 64); end // R2
        default: begin // R8
          for (int i = 0; i < 64; i++) begin
            step(1'b0, 1'b1, 1'b0, ~kbit(i));
            step(1'b1, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b1, 1'b1, kbit(i));
          end
        end
      endcase
      check(s_cap == exp_u, "R3 capture on last key bit", 64'(s_cap), 64'(exp_u));
      check(s_inh == 1'b0, "R4 final key write not inhibited", 64'(s_inh), 64'd0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check(s_inh == exp_u, "R4 inhibit after key", 64'(s_inh), 64'(exp_u));
      if (exp_u) begin
        drain_reads(0, IMG_A);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(s_ld && !s_inh && s_lmask == 8'h00, "R7 end of all-read transfer",
              {s_lmask, 54'd0, s_ld, s_inh}, {8'h00, 54'd0, 1'b1, 1'b0});
      end
    end

    // R1 both strobes count as read
    step(1'b1, 1'b0, 1'b1, 1'b0);
    send_key(0, 30);
    step(1'b1, 1'b1, 1'b1, kbit(30));
    send_key(0, 64);
    check(s_cap == 1'b1, "R1 dual strobe rewinds", 64'(s_cap), 64'd1);
    drain_reads(0, IMG_A);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // R5 R7 full write transfer
    step(1'b1, 1'b0, 1'b1, 1'b0);
    send_key(0, 64);
    for (int i = 0; i < 64; i++) begin
      step(1'b0, 1'b1, 1'b1, WPAT[i]);
      if (i == 0 || i == 63) check(s_inh == 1'b1, "R4 inhibit during transfer", 64'(s_inh), 64'd1);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_ld == 1'b1, "R7 load strobe", 64'(s_ld), 64'd1);
    check(s_ldata == WPAT, "R5 write image", s_ldata, WPAT);
    check(s_lmask == 8'hFF, "R7 full mask", 64'(s_lmask), 64'hFF);
    check(s_inh == 1'b0, "R7 inhibit released", 64'(s_inh), 64'd0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_ld == 1'b0, "R7 single-cycle strobe", 64'(s_ld), 64'd0);

    // R7 pointer back at 0: key again with no read; mixed transfer
    send_key(0, 64);
    check(s_cap == 1'b1, "R7 relock without read", 64'(s_cap), 64'd1);
    for (int i = 0; i < 64; i++) begin
      if (i == 30) step(1'b0, 1'b1, 1'b0, ~MPAT[i]); // R8 unselected
      if (i == 19) step(1'b1, 1'b0, 1'b1, 1'b0);
      else         step(1'b0, 1'b1, 1'b1, MPAT[i]);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_ld == 1'b1, "R7 mixed load strobe", 64'(s_ld), 64'd1);
    check(s_lmask == 8'hFB, "R7 group mask", 64'(s_lmask), 64'hFB);
    check((s_ldata & ~64'h0000_0000_00FF_0000) == (MPAT & ~64'h0000_0000_00FF_0000),
          "R5 R8 mixed write image", s_ldata, MPAT);

    // R9 abort honoured (image A, enable bit 0)
    send_key(0, 64);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(s_inh == 1'b1, "R9 still busy in abort cycle", 64'(s_inh), 64'd1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(!s_inh && !s_ld, "R9 abort without load", {62'd0, s_inh, s_ld}, 64'd0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_ld == 1'b0, "R9 no late load", 64'(s_ld), 64'd0);

    // R9 abort ignored (image B, enable bit 1); R6 snapshot vs live image
    clk_image_in = IMG_B;
    send_key(0, 64);
    check(s_cap == 1'b1, "R9 relock after abort", 64'(s_cap), 64'd1);
    clk_image_in = IMG_A;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_inh == 1'b1, "R9 abort ignored", 64'(s_inh), 64'd1);
    drain_reads(5, IMG_B);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(s_ld && s_lmask == 8'h00, "R7 load after ignored abort",
          {s_lmask, 55'd0, s_ld}, {8'h00, 55'd0, 1'b1});

    summary();
    $finish;
  end
endmodule